// File: doc/BRIEF.md
# Retired-Stream Skip Detector

This block sits at the retirement end of the trailing, full-length copy of a program. It decides, instruction by instruction, which ones a leading, shortened copy could have left out. Each retired instruction arrives with these fields:

- an optional destination register, together with the new result and the value that register held before;
- up to two optional source registers;
- a branch flag, with the prediction outcome and the direction taken;
- a store flag;
- its own address and the address that follows it.

Internally the block keeps a last-writer record for every architectural register. A record holds the window slot of the latest writer and whether anyone has read that writer's result since. For every window slot it also keeps the set of later slots that consumed the slot's result. With these it classifies three cases: writes that leave the register unchanged, writes that are overwritten before anyone reads them, and branches whose prediction was right. It then extends removal one step back along the dependence chain.

The window and the block have the same length. A block closes on its eighth instruction or on a taken branch, whichever comes first. One cycle later the block spends a single stall cycle folding its slots into a skip mask. It then presents one report for the removal predictor: the mask, the number of slots, the address of the block's first instruction, and the address that follows the block. The per-register records are discarded at every block boundary, so no classification spans two blocks.

Top module: `skip_detector`

## Requirements
- R1: A slot whose instruction writes a destination register with a result equal to that register's previous value is reported removable.
- R2: A slot whose register write is overwritten by a later slot of the same block, with no read of that register in between, is reported removable.
- R3: A slot holding a branch that retired with a correct prediction is reported removable, whether taken or not.
- R4: A slot with at least one consumer inside the block, all of whose consumers meet R1, R2 or R3 directly, is reported removable. A slot that is removable only through this rule does not make its own producers removable.
- R5: A slot flagged as a store is never reported removable, even when it also meets another removal condition. A consumer that is a store keeps its producer from qualifying under R4.
- R6: The eighth instruction of a block closes it, and the report then has a count of 8.
- R7: A taken branch closes the block after itself, at whatever slot it sits.
- R8: In the report, mask bit i describes slot i, where slot 0 is the block's first instruction. Bits at or above the count are 0. The start address is the address of slot 0. The next address is the next-address field of the closing instruction.
- R9: At most one instruction is accepted per cycle, when retVld and retRdy are both high. retRdy is low for exactly the one cycle after a closing instruction is accepted. rptVld is high for exactly one cycle, two cycles after that acceptance.
- R10: After reset, rptVld is low and retRdy is high.
- R11: A read of a register marks its current writer as referenced, so a later overwrite does not make that writer removable. This includes an instruction that reads and rewrites the same register.
- R12: All register records and slot state are cleared when a block closes, so a write in one block is never judged by instructions of the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| retVld | input | 1 | A retired instruction is offered |
| retRdy | output | 1 | The block can accept an instruction this cycle |
| retPc | input | PC_W | Address of the retired instruction |
| retNextPc | input | PC_W | Address following it (branch target if taken) |
| retDstEn | input | 1 | The instruction writes a register |
| retDst | input | REG_AW | Destination register |
| retSrcAEn | input | 1 | First source register is used |
| retSrcA | input | REG_AW | First source register |
| retSrcBEn | input | 1 | Second source register is used |
| retSrcB | input | REG_AW | Second source register |
| retResult | input | DATA_W | New value written to the destination |
| retOldVal | input | DATA_W | Value the destination held before |
| retIsBranch | input | 1 | The instruction is a branch |
| retBrCorrect | input | 1 | Its prediction was correct |
| retBrTaken | input | 1 | The branch was taken |
| retIsStore | input | 1 | The instruction is a store |
| rptVld | output | 1 | Block report valid (one-cycle pulse) |
| rptMask | output | WIN | Removable slots, bit i for slot i |
| rptCount | output | SLOT_W+1 | Number of slots in the block |
| rptStartPc | output | PC_W | Address of the block's first instruction |
| rptNextPc | output | PC_W | Address following the block |

## Verification
Some properties are checked by assertions on every cycle at each report:

- direct classifications (unchanged writes, dead writes, correct branches) always show up in the mask;
- stores never do;
- mask bits beyond the count stay clear;
- the ready and report signals follow the one-stall, one-pulse timing.

Other behaviour shows only in the directed scenarios:

- the one-level limit of dependence propagation;
- a read, including a self-read, protecting a writer from being called dead;
- records being forgotten across a block boundary;
- the exact start and next addresses.

// File: rtl/skip_pkg.sv
package skip_pkg;

  // Strobes from the control to the datapath, one cycle each.
  typedef struct packed {
    logic accept;     // an instruction is taken this cycle
    logic firstSlot;  // it is the first of its block
    logic endBlock;   // it closes the block
    logic flush;      // fold the window into a report and clear it
  } strobe_t;

endpackage

// File: rtl/skip_ctrl.sv
module skip_ctrl
  import skip_pkg::*;
#(
  parameter int WIN = 8,
  localparam int SLOT_W = (WIN > 1) ? $clog2(WIN) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              retVld,
  input  logic              takenBranch,
  output logic              retRdy,
  output logic [SLOT_W-1:0] slot,
  output strobe_t           strb
);

  logic              flushing;
  logic [SLOT_W-1:0] slotIdx;
  logic              lastSlot;

  assign lastSlot = (slotIdx == SLOT_W'(WIN - 1));

  always_comb begin
    strb           = '0;
    strb.accept    = retVld & ~flushing;
    strb.firstSlot = strb.accept & (slotIdx == '0);
    strb.endBlock  = strb.accept & (lastSlot | takenBranch);
    strb.flush     = flushing;
  end

  assign retRdy = ~flushing;
  assign slot   = slotIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flushing <= 1'b0;
      slotIdx  <= '0;
    end else if (flushing) begin
      flushing <= 1'b0;
    end else if (strb.accept) begin
      if (strb.endBlock) begin
        flushing <= 1'b1;
        slotIdx  <= '0;
      end else begin
        slotIdx  <= slotIdx + 1'b1;
      end
    end
  end

  AST_STALL_AFTER_END: assert property (@(posedge clk) disable iff (!rstN)
    strb.endBlock |=> !retRdy); // R9

  AST_SINGLE_STALL: assert property (@(posedge clk) disable iff (!rstN)
    !retRdy |=> retRdy); // R9

  AST_EIGHTH_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    (strb.accept && lastSlot) |=> (slotIdx == '0)); // R6

endmodule

// File: rtl/skip_datapath.sv
module skip_datapath
  import skip_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int WIN      = 8,
  parameter int DATA_W   = 32,
  parameter int PC_W     = 32,
  localparam int REG_AW  = $clog2(NUM_REGS),
  localparam int SLOT_W  = (WIN > 1) ? $clog2(WIN) : 1,
  localparam int CNT_W   = SLOT_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [SLOT_W-1:0] slot,
  input  logic [PC_W-1:0]   retPc,
  input  logic [PC_W-1:0]   retNextPc,
  input  logic              retDstEn,
  input  logic [REG_AW-1:0] retDst,
  input  logic              retSrcAEn,
  input  logic [REG_AW-1:0] retSrcA,
  input  logic              retSrcBEn,
  input  logic [REG_AW-1:0] retSrcB,
  input  logic [DATA_W-1:0] retResult,
  input  logic [DATA_W-1:0] retOldVal,
  input  logic              retIsBranch,
  input  logic              retBrCorrect,
  input  logic              retIsStore,
  output logic              rptVld,
  output logic [WIN-1:0]    rptMask,
  output logic [CNT_W-1:0]  rptCount,
  output logic [PC_W-1:0]   rptStartPc,
  output logic [PC_W-1:0]   rptNextPc
);

  // Last-writer record per architectural register
  logic [NUM_REGS-1:0] recValid;
  logic [NUM_REGS-1:0] recRef;
  logic [SLOT_W-1:0]   recSlot [NUM_REGS];

  // Per-slot classification state
  logic [WIN-1:0] slotValid;
  logic [WIN-1:0] nonMod;
  logic [WIN-1:0] brOk;
  logic [WIN-1:0] dead;
  logic [WIN-1:0] storeV;
  logic [WIN-1:0] consMask [WIN];

  logic [PC_W-1:0] startPcHold;
  logic [PC_W-1:0] nextPcHold;

  // Hazard decode for the incoming instruction
  logic srcAHit, srcBHit, selfRead, deadHit;

  assign srcAHit  = retSrcAEn & recValid[retSrcA];
  assign srcBHit  = retSrcBEn & recValid[retSrcB];
  assign selfRead = (retSrcAEn & (retSrcA == retDst)) |
                    (retSrcBEn & (retSrcB == retDst));
  assign deadHit  = retDstEn & recValid[retDst] & ~recRef[retDst] & ~selfRead;

  // Fold window into a skip mask
  logic [WIN-1:0]   direct;
  logic [WIN-1:0]   chained;
  logic [WIN-1:0]   foldMask;
  logic [CNT_W-1:0] foldCount;

  assign direct = nonMod | brOk | dead;

  generate
    for (genvar i = 0; i < WIN; i++) begin : g_fold
      assign chained[i]  = (|consMask[i]) && ((consMask[i] & ~(direct & ~storeV)) == '0);
      assign foldMask[i] = slotValid[i] & ~storeV[i] & (direct[i] | chained[i]);
    end
  endgenerate

  always_comb begin
    foldCount = '0;
    for (int i = 0; i < WIN; i++) begin
      foldCount = foldCount + CNT_W'(slotValid[i]);
    end
  end

  // Register records
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      recValid <= '0;
      recRef   <= '0;
      for (int r = 0; r < NUM_REGS; r++) recSlot[r] <= '0;
    end else if (strb.flush) begin
      recValid <= '0;
      recRef   <= '0;
    end else if (strb.accept) begin
      if (srcAHit) recRef[retSrcA] <= 1'b1;
      if (srcBHit) recRef[retSrcB] <= 1'b1;
      if (retDstEn) begin
        recValid[retDst] <= 1'b1;
        recRef[retDst]   <= 1'b0;
        recSlot[retDst]  <= slot;
      end
    end
  end

  // Slot state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotValid <= '0;
      nonMod    <= '0;
      brOk      <= '0;
      dead      <= '0;
      storeV    <= '0;
      for (int i = 0; i < WIN; i++) consMask[i] <= '0;
    end else if (strb.flush) begin
      slotValid <= '0;
      nonMod    <= '0;
      brOk      <= '0;
      dead      <= '0;
      storeV    <= '0;
      for (int i = 0; i < WIN; i++) consMask[i] <= '0;
    end else if (strb.accept) begin
      slotValid[slot] <= 1'b1;
      nonMod[slot]    <= retDstEn & (retResult == retOldVal);
      brOk[slot]      <= retIsBranch & retBrCorrect;
      storeV[slot]    <= retIsStore;
      if (srcAHit) consMask[recSlot[retSrcA]][slot] <= 1'b1;
      if (srcBHit) consMask[recSlot[retSrcB]][slot] <= 1'b1;
      if (deadHit) dead[recSlot[retDst]] <= 1'b1;
    end
  end

  // Block addresses
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startPcHold <= '0;
      nextPcHold  <= '0;
    end else begin
      if (strb.firstSlot) startPcHold <= retPc;
      if (strb.endBlock)  nextPcHold  <= retNextPc;
    end
  end

  // Report registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rptVld     <= 1'b0;
      rptMask    <= '0;
      rptCount   <= '0;
      rptStartPc <= '0;
      rptNextPc  <= '0;
    end else begin
      rptVld <= strb.flush;
      if (strb.flush) begin
        rptMask    <= foldMask;
        rptCount   <= foldCount;
        rptStartPc <= startPcHold;
        rptNextPc  <= nextPcHold;
      end
    end
  end

  AST_NONMOD_REPORTED: assert property (@(posedge clk) disable iff (!rstN)
    rptVld |-> ((rptMask & $past(nonMod & slotValid & ~storeV)) ==
                $past(nonMod & slotValid & ~storeV))); // R1

  AST_DEAD_REPORTED: assert property (@(posedge clk) disable iff (!rstN)
    rptVld |-> ((rptMask & $past(dead & slotValid & ~storeV)) ==
                $past(dead & slotValid & ~storeV))); // R2

  AST_BRANCH_REPORTED: assert property (@(posedge clk) disable iff (!rstN)
    rptVld |-> ((rptMask & $past(brOk & slotValid & ~storeV)) ==
                $past(brOk & slotValid & ~storeV))); // R3

  AST_STORE_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    rptVld |-> ((rptMask & $past(storeV)) == '0)); // R5

  AST_TAIL_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    rptVld |-> ((rptMask >> rptCount) == '0)); // R8

  AST_RPT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rptVld |=> !rptVld); // R9

  AST_WINDOW_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    rptVld |-> (slotValid == '0 && recValid == '0)); // R12

endmodule

// File: rtl/skip_detector.sv
module skip_detector
  import skip_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int WIN      = 8,
  parameter int DATA_W   = 32,
  parameter int PC_W     = 32,
  localparam int REG_AW  = $clog2(NUM_REGS),
  localparam int SLOT_W  = (WIN > 1) ? $clog2(WIN) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              retVld,
  output logic              retRdy,
  input  logic [PC_W-1:0]   retPc,
  input  logic [PC_W-1:0]   retNextPc,
  input  logic              retDstEn,
  input  logic [REG_AW-1:0] retDst,
  input  logic              retSrcAEn,
  input  logic [REG_AW-1:0] retSrcA,
  input  logic              retSrcBEn,
  input  logic [REG_AW-1:0] retSrcB,
  input  logic [DATA_W-1:0] retResult,
  input  logic [DATA_W-1:0] retOldVal,
  input  logic              retIsBranch,
  input  logic              retBrCorrect,
  input  logic              retBrTaken,
  input  logic              retIsStore,
  output logic              rptVld,
  output logic [WIN-1:0]    rptMask,
  output logic [SLOT_W:0]   rptCount,
  output logic [PC_W-1:0]   rptStartPc,
  output logic [PC_W-1:0]   rptNextPc
);

  strobe_t           strb;
  logic [SLOT_W-1:0] slot;

  skip_ctrl #(.WIN(WIN)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .retVld      (retVld),
    .takenBranch (retIsBranch & retBrTaken),
    .retRdy      (retRdy),
    .slot        (slot),
    .strb        (strb)
  );

  skip_datapath #(
    .NUM_REGS (NUM_REGS),
    .WIN      (WIN),
    .DATA_W   (DATA_W),
    .PC_W     (PC_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .slot         (slot),
    .retPc        (retPc),
    .retNextPc    (retNextPc),
    .retDstEn     (retDstEn),
    .retDst       (retDst),
    .retSrcAEn    (retSrcAEn),
    .retSrcA      (retSrcA),
    .retSrcBEn    (retSrcBEn),
    .retSrcB      (retSrcB),
    .retResult    (retResult),
    .retOldVal    (retOldVal),
    .retIsBranch  (retIsBranch),
    .retBrCorrect (retBrCorrect),
    .retIsStore   (retIsStore),
    .rptVld       (rptVld),
    .rptMask      (rptMask),
    .rptCount     (rptCount),
    .rptStartPc   (rptStartPc),
    .rptNextPc    (rptNextPc)
  );

endmodule

// File: tb/skip_detector_bench.sv
module skip_detector_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        retVld = 1'b0;
  logic        retRdy;
  logic [31:0] retPc = '0, retNextPc = '0;
  logic        retDstEn = 1'b0, retSrcAEn = 1'b0, retSrcBEn = 1'b0;
  logic [4:0]  retDst = '0, retSrcA = '0, retSrcB = '0;
  logic [31:0] retResult = '0, retOldVal = '0;
  logic        retIsBranch = 1'b0, retBrCorrect = 1'b0, retBrTaken = 1'b0, retIsStore = 1'b0;
  logic        rptVld;
  logic [7:0]  rptMask;
  logic [3:0]  rptCount;
  logic [31:0] rptStartPc, rptNextPc;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic [31:0] pcCtr = 32'h1000;
  logic [31:0] blkStart;

  skip_detector u_skip_detector (
    .clk(clk), .rstN(rstN), .retVld(retVld), .retRdy(retRdy),
    .retPc(retPc), .retNextPc(retNextPc),
    .retDstEn(retDstEn), .retDst(retDst),
    .retSrcAEn(retSrcAEn), .retSrcA(retSrcA),
    .retSrcBEn(retSrcBEn), .retSrcB(retSrcB),
    .retResult(retResult), .retOldVal(retOldVal),
    .retIsBranch(retIsBranch), .retBrCorrect(retBrCorrect),
    .retBrTaken(retBrTaken), .retIsStore(retIsStore),
    .rptVld(rptVld), .rptMask(rptMask), .rptCount(rptCount),
    .rptStartPc(rptStartPc), .rptNextPc(rptNextPc)
  );

  always #5 clk = ~clk;

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected<=20000", cycles);
      summary();
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic dEn, input int d, input logic aEn, input int a,
                       input logic bEn, input int b, input logic [31:0] res,
                       input logic [31:0] old, input logic isBr, input logic ok,
                       input logic taken, input logic st, input logic [31:0] target);
    while (!retRdy) @(negedge clk);
    retVld = 1'b1;
    retPc = pcCtr;
    retNextPc = (isBr && taken) ? target : pcCtr + 32'd4;
    retDstEn = dEn;  retDst = d[4:0];
    retSrcAEn = aEn; retSrcA = a[4:0];
    retSrcBEn = bEn; retSrcB = b[4:0];
    retResult = res; retOldVal = old;
    retIsBranch = isBr; retBrCorrect = ok; retBrTaken = taken; retIsStore = st;
    pcCtr = retNextPc;
    @(negedge clk);
    retVld = 1'b0;
  endtask

  task automatic wr(input int d, input logic [31:0] res, input logic [31:0] old);
    issue(1, d, 0, 0, 0, 0, res, old, 0, 0, 0, 0, 0);
  endtask

  task automatic wrA(input int d, input int a, input logic [31:0] res, input logic [31:0] old);
    issue(1, d, 1, a, 0, 0, res, old, 0, 0, 0, 0, 0);
  endtask

  task automatic br(input logic ok, input logic taken, input logic aEn, input int a,
                    input logic [31:0] target);
    issue(0, 0, aEn, a, 0, 0, 0, 0, 1, ok, taken, 0, target);
  endtask

  // Called right after the closing instruction was accepted.
  task automatic expectReport(input string req, input logic [7:0] mask, input int cnt,
                              input logic [31:0] nextPc);
    chk({req, " R9 ready low after close"}, retRdy, 0);
    chk({req, " R9 no early report"}, rptVld, 0);
    @(negedge clk);
    chk({req, " R9 report valid"}, rptVld, 1);
    chk({req, " mask"}, rptMask, mask);
    chk({req, " R8 count"}, rptCount, cnt);
    chk({req, " R8 startPc"}, rptStartPc, blkStart);
    chk({req, " R8 nextPc"}, rptNextPc, nextPc);
    chk({req, " R9 ready back"}, retRdy, 1);
    @(negedge clk);
    chk({req, " R9 one-cycle pulse"}, rptVld, 0);
  endtask

  task automatic testReset();
    chk("R10 rptVld after reset", rptVld, 0);
    chk("R10 retRdy after reset", retRdy, 1);
  endtask

  // R1 unchanged write, R7 mispredicted taken branch closes block
  task automatic testNonMod();
    blkStart = pcCtr;
    wr(1, 5, 5);
    wr(2, 7, 3);
    br(0, 1, 0, 0, 32'h2000);
    expectReport("R1/R7", 8'b0000_0001, 3, 32'h2000);
  endtask

  // R2 dead write, R11 read protects writer (also self-read), R6 eight slots
  task automatic testDead();
    blkStart = pcCtr;
    wr(3, 1, 0);
    wr(3, 2, 1);
    wr(4, 9, 0);
    wrA(5, 4, 1, 0);
    wr(4, 8, 9);
    wr(6, 3, 0);
    wrA(6, 6, 4, 3);
    wr(7, 0, 5);
    expectReport("R2/R11/R6", 8'b0000_0001, 8, blkStart + 32'd32);
  endtask

  // R3 correct branches, R4 one level of propagation only
  task automatic testChain();
    blkStart = pcCtr;
    wr(1, 10, 0);
    wrA(2, 1, 20, 0);
    br(1, 0, 1, 2, 0);
    br(1, 1, 0, 0, 32'h3000);
    expectReport("R3/R4", 8'b0000_1110, 4, 32'h3000);
  endtask

  // R5 store never removable, nor lets its producer qualify
  task automatic testStore();
    blkStart = pcCtr;
    wr(2, 1, 0);
    issue(1, 9, 1, 2, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    wr(2, 5, 1);
    br(0, 1, 0, 0, 32'h4000);
    expectReport("R5", 8'b0000_0000, 4, 32'h4000);
  endtask

  // R12 records forgotten at the boundary
  task automatic testBoundary();
    blkStart = pcCtr;
    wr(10, 1, 0);
    br(0, 1, 0, 0, 32'h5000);
    expectReport("R12 first block", 8'b0000_0000, 2, 32'h5000);
    blkStart = pcCtr;
    wr(10, 2, 1);
    br(0, 1, 0, 0, 32'h6000);
    expectReport("R12 second block", 8'b0000_0000, 2, 32'h6000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testNonMod();
    testDead();
    testChain();
    testStore();
    testBoundary();
    summary();
  end

endmodule